// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by reading a tree of page tables from memory. Each table is a single 4 KiB page that holds 1024 four-byte entries. A virtual address has 42 bits: three 10-bit index fields above a 12-bit page offset. The top index selects an entry in the root directory. The middle index selects an entry in the second-level directory named by that entry. The lowest index selects an entry in the leaf table, and that entry names the data frame. The page offset passes through to the result unchanged.

The caller presents the address together with the frame number of the root directory, taken from a page-table pointer register held outside the block. The walker then issues up to three single-word reads on a valid/ready request channel and waits for each read's data on a response channel that carries a valid strobe. An entry whose present bit is clear stops the walk and reports a fault, and the report names the level where the walk stopped. Only one walk is active at a time, and only one read is outstanding at a time.

Top module: `pt_walker`

## Requirements
- R1: After synchronous reset the walker is idle: `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. While a walk is running, `req_ready` is 0, and a request presented then changes neither the result nor the read addresses.
- R3: The first read address is `{root_frame, va[41:32], 2'b00}`.
- R4: The second read address is `{F1, va[31:22], 2'b00}` and the third is `{F2, va[21:12], 2'b00}`, where F1 and F2 are the frame fields of the first and second entries.
- R5: Entry format: bit 0 is the present flag, bits [31:12] hold the frame number, and bits [11:1] are ignored.
- R6: An entry whose present bit is 0 ends the walk without any further read. It raises `fault` together with `done`, sets `fault_level` to the level where the walk stopped (0 = root directory, 1 = second directory, 2 = leaf table), and drives `pa` to 0.
- R7: When all three entries are present, `done` rises with `fault` at 0 and `pa = {F3, va[11:0]}`, where F3 is the frame field of the leaf entry.
- R8: `done` is a single-cycle pulse. It appears in the cycle after the clock edge that captures the last response of the walk.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` stays stable.
- R10: After a read is accepted, no new read is issued until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 42 | Virtual address to translate |
| root_frame | input | 20 | Frame number of the root directory |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a non-present entry |
| fault_level | output | 2 | Level at which the walk stopped |
| pa | output | 32 | Translated physical address |

## Verification
The memory model in the bench answers with a random acceptance delay and a random response latency of zero to two cycles, so the timing of a walk varies from run to run. For every walk, the bench notes the cycle in which it drove the final response. It then expects `done` exactly one cycle later, samples there on the falling edge, and checks on the next falling edge that `done` has returned to 0. The read addresses are logged at each request handshake and compared, in order and in number, with the list the bench computes from the tables it built. A fault must leave that list short at the faulting level. Requests presented during a walk are driven in the cycle just after acceptance, where `req_ready` must already read 0.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2
  } walk_state_t;
endpackage

// File: rtl/pt_index_sel.sv
module pt_index_sel #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 2,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] index
);
  logic [IDX_W-1:0] slice [LEVELS];

  // level 0 takes the most significant field
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    index = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) index = slice[i];
    end
  end
endmodule

// File: rtl/pt_entry_fmt.sv
module pt_entry_fmt #(
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int PAD_W  = OFF_W - IDX_W
) (
  input  logic [FRAME_W-1:0] base,
  input  logic [IDX_W-1:0]   index,
  input  logic [PA_W-1:0]    entry,
  output logic [PA_W-1:0]    entry_addr,
  output logic               present,
  output logic [FRAME_W-1:0] next_frame
);
  // entry byte address: table base plus index scaled by the entry size
  assign entry_addr = {base, index, {PAD_W{1'b0}}};
  assign present    = entry[0];
  assign next_frame = entry[PA_W-1:OFF_W];
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd_accept,
  input  logic             rsp_valid,
  input  logic             present,
  output logic             idle,
  output logic             rd_valid,
  output logic [LVL_W-1:0] level,
  output logic             step,
  output logic             finish_ok,
  output logic             finish_fault
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

  walk_state_t state;
  logic        rsp_here;

  assign rsp_here     = (state == W_WAIT) && rsp_valid;
  assign idle         = (state == W_IDLE);
  assign rd_valid     = (state == W_ISSUE);
  assign step         = rsp_here && present && (level != LAST);
  assign finish_ok    = rsp_here && present && (level == LAST);
  assign finish_fault = rsp_here && !present;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= W_IDLE;
      level <= '0;
    end else begin
      case (state)
        W_IDLE: if (start) begin
          state <= W_ISSUE;
          level <= '0;
        end
        W_ISSUE: if (rd_accept) state <= W_WAIT;
        W_WAIT: if (rsp_valid) begin
          if (step) begin
            level <= level + 1'b1;
            state <= W_ISSUE;
          end else begin
            state <= W_IDLE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int LEVELS  = 3,
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  localparam int VA_W   = LEVELS * IDX_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PA_W-1:0]    mem_rsp_data,
  output logic               done,
  output logic               fault,
  output logic [LVL_W-1:0]   fault_level,
  output logic [PA_W-1:0]    pa
);
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] base_q;
  logic [LVL_W-1:0]   level;
  logic [IDX_W-1:0]   index;
  logic               present;
  logic [FRAME_W-1:0] next_frame;
  logic               idle, start, step, finish_ok, finish_fault;

  assign start     = req_valid && idle;
  assign req_ready = idle;

  pt_walk_ctrl #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .rd_accept    (mem_req_ready),
    .rsp_valid    (mem_rsp_valid),
    .present      (present),
    .idle         (idle),
    .rd_valid     (mem_req_valid),
    .level        (level),
    .step         (step),
    .finish_ok    (finish_ok),
    .finish_fault (finish_fault)
  );

  pt_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W)) u_idx (
    .vaddr (va_q),
    .level (level),
    .index (index)
  );

  pt_entry_fmt #(.IDX_W(IDX_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_fmt (
    .base       (base_q),
    .index      (index),
    .entry      (mem_rsp_data),
    .entry_addr (mem_req_addr),
    .present    (present),
    .next_frame (next_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q        <= '0;
      base_q      <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= '0;
      pa          <= '0;
    end else begin
      done <= finish_ok || finish_fault;
      if (start) begin
        va_q   <= req_vaddr;
        base_q <= root_frame;
      end
      if (step) base_q <= next_frame;
      if (finish_ok) begin
        pa          <= {next_frame, va_q[OFF_W-1:0]};
        fault       <= 1'b0;
        fault_level <= '0;
      end
      if (finish_fault) begin
        pa          <= '0;
        fault       <= 1'b1;
        fault_level <= level;
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            done
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pend <= 1'b1;
    else if (mem_rsp_valid) pend <= 1'b0;
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_single_read: assert property (@(posedge clk) disable iff (rst)
    pend |-> !mem_req_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_rsp: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rsp_valid));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [41:0] req_vaddr;
  logic [19:0] root_frame;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic [1:0]  fault_level;
  logic [31:0] pa;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_frame(root_frame),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_level(fault_level), .pa(pa)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] got_addr [$];
  logic [31:0] exp_addr [$];
  int unsigned cyc = 0;
  int unsigned rsp_cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [9:0] idx_of(input logic [41:0] va, input int l);
    return va[12 + (2 - l) * 10 +: 10];
  endfunction

  // memory model: random acceptance and 0..2 cycle response latency
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = ($urandom_range(0, 2) != 0);
      if (mem_req_valid && mem_req_ready && !rst) begin
        automatic logic [31:0] a = mem_req_addr;
        automatic int lat = $urandom_range(0, 2);
        got_addr.push_back(a);
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(a);
        rsp_cyc = cyc;
      end
    end
  end

  // builds a tree for va; fault_at 0..2 makes that level not present, 3 = none
  task automatic build(input logic [41:0] va, input logic [19:0] root,
                       input int fault_at, output logic [19:0] leaf);
    logic [19:0] base = root;
    mem.delete();
    leaf = '0;
    for (int l = 0; l < 3; l++) begin
      automatic logic [31:0] a = {base, idx_of(va, l), 2'b00};
      automatic logic [19:0] f = 20'($urandom);
      automatic logic [10:0] junk = 11'($urandom);
      if (l == fault_at) begin
        mem[a] = {f, junk, 1'b0};
        break;
      end
      mem[a] = {f, junk, 1'b1};
      base = f;
      leaf = f;
    end
  endtask

  task automatic run_walk(input logic [41:0] va, input logic [19:0] root,
                          input bit junk_req);
    logic [19:0] base = root;
    bit exp_fault = 0;
    logic [1:0] exp_lvl = 0;
    logic [31:0] exp_pa = 0;
    int t = 0;
    exp_addr.delete();
    got_addr.delete();
    for (int l = 0; l < 3; l++) begin
      automatic logic [31:0] a = {base, idx_of(va, l), 2'b00};
      automatic logic [31:0] e = rd(a);
      exp_addr.push_back(a);
      if (!e[0]) begin
        exp_fault = 1;
        exp_lvl = 2'(l);
        break;
      end
      base = e[31:12];
    end
    if (!exp_fault) exp_pa = {base, va[11:0]};

    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; root_frame = root;
    @(negedge clk);
    req_valid = 1'b0;
    if (junk_req) begin
      chk(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 64'd0);
      req_valid = 1'b1; req_vaddr = ~va; root_frame = ~root;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R8", "done seen", 64'(done), 64'd1);
    chk(cyc == rsp_cyc + 1, "R8", "done timing", 64'(cyc), 64'(rsp_cyc + 1));
    chk(fault == exp_fault, "R6", "fault flag", 64'(fault), 64'(exp_fault));
    if (exp_fault)
      chk(fault_level == exp_lvl, "R6", "fault level", 64'(fault_level), 64'(exp_lvl));
    chk(pa == exp_pa, exp_fault ? "R6" : "R7", "pa", 64'(pa), 64'(exp_pa));
    chk(got_addr.size() == exp_addr.size(), "R10", "read count",
        64'(got_addr.size()), 64'(exp_addr.size()));
    for (int i = 0; i < exp_addr.size() && i < got_addr.size(); i++)
      chk(got_addr[i] == exp_addr[i], (i == 0) ? "R3" : "R4", "read address",
          64'(got_addr[i]), 64'(exp_addr[i]));
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] leaf;
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; root_frame = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    // R6 directed: fault at each level; R5 junk bits ignored on entries
    for (int l = 0; l < 3; l++) begin
      build(42'h2AB_CDEF_1234, 20'h00321, l, leaf);
      run_walk(42'h2AB_CDEF_1234, 20'h00321, 1'b0);
    end
    // R7 directed corners: all-zero and all-one indices, root frame zero
    build(42'h0, 20'h0, 3, leaf);
    run_walk(42'h0, 20'h0, 1'b0);
    build({42{1'b1}}, 20'hFFFFF, 3, leaf);
    run_walk({42{1'b1}}, 20'hFFFFF, 1'b0);
    // R2 directed: request during walk ignored
    build(42'h155_5555_5555, 20'h0ABCD, 3, leaf);
    run_walk(42'h155_5555_5555, 20'h0ABCD, 1'b1);

    // random walks, R5 entries carry random ignored low bits
    for (int n = 0; n < 200; n++) begin
      automatic logic [41:0] va = {10'($urandom), 32'($urandom)};
      automatic logic [19:0] root = 20'($urandom);
      automatic int fa = $urandom_range(0, 5);
      build(va, root, (fa > 3) ? 3 : fa, leaf);
      run_walk(va, root, $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule